// File: doc/BRIEF.md
# Receive Error Event Monitor

This block sits beside the receive path of a cell-reassembly engine and gathers its error indications. Seven kinds of one-cycle pulse arrive, each with the channel number of the cell it concerns. Five are header faults: sequence-byte parity, sequence-byte CRC, sequence number, pointer-byte parity and pointer out of range. The two pointer faults only occur on cells that carry a pointer. The other two are buffer write underrun and write overrun. Every pulse sets a sticky status bit.

Three 16-bit counters record how often events happen, and each counter has a register that holds the channel of the last counted event. Underrun and overrun each have their own counter. The five header faults share one miscellaneous counter, and a per-type select bit in the control register decides which of them are counted. When a counter wraps, it raises a rollover status bit of its own. Each of the ten status bits has an interrupt enable. A registered service-request output is high while any enabled status bit is set. A test bit in the control register forces every event on every cycle while it is high.

Software reaches all state through a synchronous write port with a combinational read-back at a 3-bit address. Address 0 is control, 1 is status, 2/3 are the miscellaneous count and ID, 4/5 are the underrun count and ID, and 6/7 are the overrun count and ID.

Top module: `rx_err_monitor`

## Requirements
- R1: After reset, control, status, the three counters, the three ID registers and `srv_req` all read 0.
- R2: Control (address 0) is a 16-bit read/write register. Bits [4:0] are header-fault select bits, with type index 0 = seq parity, 1 = seq CRC, 2 = seq number, 3 = pointer parity and 4 = pointer range. Bits [14:5] are the interrupt enables for status bits 0..9, with bit 5+k enabling status k. Bit 15 is the test bit.
- R3: In the status register (address 1), bits 0..4 set on `hdr_err[0..4]` whatever the select bits are. Bit 5 sets on underrun and bit 6 on overrun. Bits 7, 8 and 9 are the miscellaneous, underrun and overrun rollover bits.
- R4: Status bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it alone. If an event sets a bit in the same cycle as a clear write to it, the bit stays 1.
- R5: The miscellaneous counter increments once in each cycle in which at least one selected header fault pulses. Faults that are not selected neither count nor change the ID register.
- R6: When several selected faults arrive together, the miscellaneous ID register takes the channel of the lowest-indexed one.
- R7: An underrun pulse increments the underrun counter and loads its channel into the underrun ID register. An overrun pulse does the same for the overrun counter and overrun ID register.
- R8: A counter wraps from 0xFFFF to 0x0000, and the cycle of that wrap sets its rollover status bit. Before the wrap, the rollover bit stays 0.
- R9: Any write to a counter address clears that counter. If an increment arrives in the same cycle, the clear wins.
- R10: `srv_req` rises one cycle after an enabled status bit sets. It stays 0 while the matching enable is 0, and it falls one cycle after the last enabled bit is cleared.
- R11: In each cycle that the test bit is 1, all ten status bits set and all three counters increment, whatever the select bits are. The ID registers load `hdr_chan` type 0, `und_chan` and `ovr_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_err | input | 5 | Header fault pulses, one bit per type |
| hdr_chan | input | 5*CH_W | Channel per header fault type, type k at [k*CH_W +: CH_W] |
| und_evt | input | 1 | Write underrun pulse |
| und_chan | input | CH_W | Underrun channel |
| ovr_evt | input | 1 | Write overrun pulse |
| ovr_chan | input | CH_W | Overrun channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| srv_req | output | 1 | Registered service request |

## Verification
The assertions assume that event inputs are only meaningful while `rst_n` is high. They also assume that a counter clear and an increment may coincide, and that the channel buses are held stable whenever their pulse is high. The stimulus changes every input on the falling clock edge and drives channel values as fixed per-type constants. It holds pulses high across many cycles only in the wrap run, where each held cycle is meant as a separate event. Register writes are never issued to two addresses in the same cycle, so each clear acts on one counter at a time.

// File: rtl/rxem_pkg.sv
package rxem_pkg;
    localparam int N_HDR  = 5;
    localparam int N_STAT = 10;
    localparam int N_CNT  = 3;
    localparam int REG_W  = 16;

    localparam int ST_UND       = 5;
    localparam int ST_OVR       = 6;
    localparam int ST_WRAP_BASE = 7;

    localparam int SEL_LSB  = 0;
    localparam int IEN_LSB  = N_HDR;
    localparam int TEST_BIT = REG_W - 1;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_MCNT = 3'd2,
        A_MID  = 3'd3,
        A_UCNT = 3'd4,
        A_UID  = 3'd5,
        A_OCNT = 3'd6,
        A_OID  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/rxem_evt_counter.sv
module rxem_evt_counter #(
    parameter int CNT_W = 16,
    parameter int ID_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic [ID_W-1:0]  inc_id,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic [ID_W-1:0]  last_id,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            last_id <= '0;
        end else begin
            if (clr)
                count <= '0;
            else if (inc)
                count <= count + 1'b1;
            if (inc && !clr)
                last_id <= inc_id;
        end
    end

    assign wrap = inc && !clr && (count == CNT_MAX);

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> count == $past(count) + 1'b1);
    // R9
    cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    // R5
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> ($stable(count) && $stable(last_id)));
endmodule

// File: rtl/rxem_status.sv
module rxem_status #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~clr) | set;
    end

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(clr)) & ~status) == '0));
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((status & $past(set)) == $past(set)));
endmodule

// File: rtl/rx_err_monitor.sv
module rx_err_monitor
    import rxem_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_HDR-1:0]      hdr_err,
    input  logic [N_HDR*CH_W-1:0] hdr_chan,
    input  logic                  und_evt,
    input  logic [CH_W-1:0]       und_chan,
    input  logic                  ovr_evt,
    input  logic [CH_W-1:0]       ovr_chan,
    input  logic                  reg_we,
    input  logic [2:0]            reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  srv_req
);
    logic [REG_W-1:0]  ctrl_q;
    logic [N_STAT-1:0] status_q;
    logic [N_STAT-1:0] stat_set;
    logic [N_STAT-1:0] stat_clr;
    logic [N_HDR-1:0]  sel;
    logic [N_STAT-1:0] ien;
    logic              test;
    logic [N_HDR-1:0]  misc_hit;
    logic [CH_W-1:0]   misc_id;
    logic [N_CNT-1:0]  cnt_inc;
    logic [N_CNT-1:0]  cnt_clr;
    logic [N_CNT-1:0]  cnt_wrap;
    logic [CH_W-1:0]   cnt_in_id [N_CNT];
    logic [CNT_W-1:0]  cnt_val   [N_CNT];
    logic [CH_W-1:0]   cnt_id    [N_CNT];
    logic              srv_q;

    assign sel      = ctrl_q[SEL_LSB +: N_HDR];
    assign ien      = ctrl_q[IEN_LSB +: N_STAT];
    assign test     = ctrl_q[TEST_BIT];
    assign misc_hit = hdr_err & sel;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (reg_we && reg_addr == A_CTRL)
            ctrl_q <= reg_wdata;
    end

    always_comb begin
        misc_id = hdr_chan[0 +: CH_W];
        for (int i = N_HDR - 1; i >= 0; i--) begin
            if (misc_hit[i])
                misc_id = hdr_chan[i*CH_W +: CH_W];
        end
    end

    assign cnt_inc[0]   = (|misc_hit) || test;
    assign cnt_inc[1]   = und_evt || test;
    assign cnt_inc[2]   = ovr_evt || test;
    assign cnt_in_id[0] = misc_id;
    assign cnt_in_id[1] = und_chan;
    assign cnt_in_id[2] = ovr_chan;

    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        assign cnt_clr[k] = reg_we && (reg_addr == 3'(A_MCNT + 2 * k));
        rxem_evt_counter #(.CNT_W(CNT_W), .ID_W(CH_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (cnt_inc[k]),
            .inc_id  (cnt_in_id[k]),
            .clr     (cnt_clr[k]),
            .count   (cnt_val[k]),
            .last_id (cnt_id[k]),
            .wrap    (cnt_wrap[k])
        );
    end

    assign stat_set = test ? '1 : {cnt_wrap, ovr_evt, und_evt, hdr_err};
    assign stat_clr = (reg_we && reg_addr == A_STAT) ? reg_wdata[N_STAT-1:0] : '0;

    rxem_status #(.N(N_STAT)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (stat_set),
        .clr    (stat_clr),
        .status (status_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            srv_q <= 1'b0;
        else
            srv_q <= |(status_q & ien);
    end
    assign srv_req = srv_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr_e'(reg_addr))
            A_CTRL: reg_rdata = ctrl_q;
            A_STAT: reg_rdata[N_STAT-1:0] = status_q;
            A_MCNT: reg_rdata[CNT_W-1:0]  = cnt_val[0];
            A_MID:  reg_rdata[CH_W-1:0]   = cnt_id[0];
            A_UCNT: reg_rdata[CNT_W-1:0]  = cnt_val[1];
            A_UID:  reg_rdata[CH_W-1:0]   = cnt_id[1];
            A_OCNT: reg_rdata[CNT_W-1:0]  = cnt_val[2];
            A_OID:  reg_rdata[CH_W-1:0]   = cnt_id[2];
        endcase
    end

    // R10
    srv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srv_req) |-> $past(|(status_q & ien)));
    // R11
    test_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test |=> (&status_q));
    // R5
    misc_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_hit == '0 && !test && !cnt_clr[0]) |=> $stable(cnt_val[0]));
    // R3
    und_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        und_evt |=> status_q[ST_UND]);
endmodule

// File: tb/rx_err_monitor_bench.sv
`timescale 1ns/1ps
module rx_err_monitor_bench;
    localparam int CH_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       hdr_err = '0;
    logic [5*CH_W-1:0] hdr_chan;
    logic             und_evt = 1'b0;
    logic [CH_W-1:0]  und_chan = 8'h55;
    logic             ovr_evt = 1'b0;
    logic [CH_W-1:0]  ovr_chan = 8'hAA;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [15:0]      reg_wdata = '0;
    logic [15:0]      reg_rdata;
    logic             srv_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    assign hdr_chan = {8'h14, 8'h13, 8'h12, 8'h11, 8'h10};

    always #2 clk = ~clk;

    rx_err_monitor #(.CH_W(CH_W), .CNT_W(16)) u_rx_err_monitor (
        .clk(clk), .rst_n(rst_n), .hdr_err(hdr_err), .hdr_chan(hdr_chan),
        .und_evt(und_evt), .und_chan(und_chan), .ovr_evt(ovr_evt),
        .ovr_chan(ovr_chan), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .srv_req(srv_req)
    );

    // {sel[4:0], err[4:0], expected increment, expected misc ID}
    localparam logic [18:0] VEC [6] = '{
        {5'b11111, 5'b00001, 1'b1, 8'h10},
        {5'b11111, 5'b10100, 1'b1, 8'h12},
        {5'b11110, 5'b00011, 1'b1, 8'h11},
        {5'b00000, 5'b11111, 1'b0, 8'h11},
        {5'b10000, 5'b01111, 1'b0, 8'h11},
        {5'b11000, 5'b11000, 1'b1, 8'h13}
    };

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        reg_addr = a;
        #0.1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: got %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_srv(input string req, input logic exp);
        checks++;
        if (srv_req !== exp) begin
            errors++;
            $display("FAIL %s srv_req: got %b expected %b", req, srv_req, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) chk("R1", 3'(a), 16'h0000);
        chk_srv("R1", 1'b0);

        // R2 control read/write
        wr(3'd0, 16'h7BCD);
        chk("R2", 3'd0, 16'h7BCD);
        wr(3'd0, 16'h0000);

        // R3 R5 R6 vector walk
        foreach (VEC[i]) begin
            wr(3'd0, {11'd0, VEC[i][18:14]});
            wr(3'd1, 16'h03FF);
            wr(3'd2, 16'h0000);
            hdr_err = VEC[i][13:9];
            @(negedge clk);
            hdr_err = '0;
            chk("R5", 3'd2, {15'd0, VEC[i][8]});
            chk("R6", 3'd3, {8'd0, VEC[i][7:0]});
            chk("R3", 3'd1, {11'd0, VEC[i][13:9]});
        end

        // R7 underrun and overrun counters
        wr(3'd1, 16'h03FF);
        und_evt = 1'b1;
        @(negedge clk);
        und_evt = 1'b0; ovr_evt = 1'b1;
        @(negedge clk);
        ovr_evt = 1'b0;
        chk("R7", 3'd4, 16'd1);
        chk("R7", 3'd5, 16'h0055);
        chk("R7", 3'd6, 16'd1);
        chk("R7", 3'd7, 16'h00AA);
        chk("R3", 3'd1, 16'h0060);

        // R4 write one clears only that bit; set wins over clear
        wr(3'd1, 16'h0020);
        chk("R4", 3'd1, 16'h0040);
        hdr_err = 5'b00001;
        wr(3'd1, 16'h0041);
        hdr_err = '0;
        chk("R4", 3'd1, 16'h0001);
        wr(3'd1, 16'h03FF);

        // R9 clear wins over increment
        und_evt = 1'b1;
        wr(3'd4, 16'hFFFF);
        und_evt = 1'b0;
        chk("R9", 3'd4, 16'd0);

        // R10 service request timing
        wr(3'd1, 16'h03FF);
        und_evt = 1'b1;
        @(negedge clk);
        und_evt = 1'b0;
        @(negedge clk);
        chk_srv("R10", 1'b0);                 // enable off
        wr(3'd0, 16'h0400);                   // enable for status 5
        chk_srv("R10", 1'b0);
        @(negedge clk);
        chk_srv("R10", 1'b1);
        wr(3'd1, 16'h0020);
        chk_srv("R10", 1'b1);
        @(negedge clk);
        chk_srv("R10", 1'b0);
        wr(3'd0, 16'h0000);

        // R11 test forcing for four cycles
        wr(3'd2, 0); wr(3'd4, 0); wr(3'd6, 0);
        wr(3'd1, 16'h03FF);
        wr(3'd0, 16'h8000);
        repeat (3) @(negedge clk);
        wr(3'd0, 16'h0000);
        chk("R11", 3'd2, 16'd4);
        chk("R11", 3'd4, 16'd4);
        chk("R11", 3'd6, 16'd4);
        chk("R11", 3'd1, 16'h03FF);
        chk("R11", 3'd3, 16'h0010);
        chk("R11", 3'd5, 16'h0055);

        // R8 wrap of all three counters
        wr(3'd0, 16'h0001);
        wr(3'd2, 0); wr(3'd4, 0); wr(3'd6, 0);
        wr(3'd1, 16'h03FF);
        hdr_err = 5'b00001; und_evt = 1'b1; ovr_evt = 1'b1;
        repeat (65535) @(negedge clk);
        chk("R8", 3'd2, 16'hFFFF);
        chk("R8", 3'd1, 16'h0061);
        @(negedge clk);
        hdr_err = '0; und_evt = 1'b0; ovr_evt = 1'b0;
        chk("R8", 3'd2, 16'h0000);
        chk("R8", 3'd4, 16'h0000);
        chk("R8", 3'd6, 16'h0000);
        chk("R8", 3'd1, 16'h03E1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule